// File: doc/BRIEF.md
# Sequential Sign-Magnitude Fractional Multiplier

This block multiplies two 16-bit ones'-complement fractions, one bit of the multiplier at a time. A start strobe loads the multiplier, which is the initial accumulator value, and the multiplicand. Both operands are reduced to magnitudes. A sign flag records the sign of the product. The multiplier magnitude moves into the low register, and the accumulator is cleared.

The iterative loop looks at the low bit of the low register on each cycle. When that bit is set, the cycle partially adds the multiplicand into the accumulator, keeps the carries in a separate carry word and clears the bit. When the bit is clear, the cycle shifts the accumulator and the low register right by one as a single pair and absorbs one stage of the pending carries.

A step counter stops the loop after the last magnitude bit has been shifted. A final cycle then resolves the remaining carries, applies the chosen rounding mode and restores the sign. The block raises a one-cycle done pulse. In round mode the result is a rounded single-length product in the accumulator. In hold mode the result is a double-length product split across the accumulator and the low register.

Top module: `sm_frac_mul`

## Requirements
- R1: While reset is high, and after it falls, `acc_out`, `low_out` and `done` are all zero until the first operation completes.
- R2: Operand conditioning treats a word with bit 15 set as negative and takes its magnitude by complementing all 16 bits. The product is negative when exactly one operand is negative. A negative zero (16'hFFFF) counts as negative.
- R3: `done` rises exactly 16 + N clock edges after the edge that samples `start`. N is the number of ones in bits 14:0 of the multiplier magnitude. Each such one costs one extra add cycle, on top of 15 shift cycles and one final cycle.
- R4: In round mode (`hold_mode` = 0), let P = 2·|multiplicand[14:0]|·|multiplier[14:0]| as a 32-bit value. `acc_out` is P[31:16], plus 1 when P[15] is 1, and `low_out` is 0.
- R5: In hold mode (`hold_mode` = 1), `acc_out` is P[31:16] with no rounding, and `low_out` is P[15:0].
- R6: A negative product complements `acc_out` in all 16 bits, so a zero magnitude gives 16'hFFFF. `low_out` is never complemented.
- R7: A `start` pulse while an operation is in progress is ignored. The running result is unchanged, and no extra `done` pulse follows.
- R8: `done` is high for exactly one cycle. `acc_out` and `low_out` keep the result until the next accepted `start`.
- R9: Carries left pending in the carry word are fully resolved. Full-scale magnitudes (16'h7FFF × 16'h7FFF) give `acc_out` = 16'h7FFE in round mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the block is idle |
| hold_mode | input | 1 | 0 = round to single length, 1 = keep the low half |
| mcand_in | input | 16 | Multiplicand, ones' complement |
| acc_in | input | 16 | Multiplier, loaded as the initial accumulator |
| done | output | 1 | One-cycle pulse when the result is valid |
| acc_out | output | 16 | Accumulator: the high or rounded product |
| low_out | output | 16 | Low register: the low product half in hold mode |

## Verification
The bench covers several corner cases:
- **Negative zeros and mixed-sign operands.** A design that takes magnitudes wrongly, or decides the sign by value instead of by bit 15, returns +0 where 16'hFFFF is due.
- **The rounding boundary.** With P[15] set and the upper half zero, a missed round-off leaves 0 instead of 1.
- **Full-scale operands.** These leave long chains of pending carries, and a design that drops the carry word or resolves it only in part is off in the low bits.
- **Latency.** The number of cycles is checked against the popcount of the multiplier, and an extra or missing step shows up there.
- **Start while busy.** A second `start` during a run must not reload the operands or raise an extra done.

// File: rtl/smm_pkg.sv
package smm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_FINAL = 2'd2
    } smm_state_e;

    typedef enum logic {
        MODE_ROUND = 1'b0,
        MODE_HOLD  = 1'b1
    } smm_mode_e;

    // Counter geometry: the loop runs W-1 shift steps and stops after the
    // shift taken while the counter shows its top bit.
    function automatic int sc_width(input int w);
        return $clog2(w) + 2;
    endfunction

    function automatic int sc_top(input int w);
        return 1 << ($clog2(w) + 1);
    endfunction

    function automatic int sc_init(input int w);
        return sc_top(w) - w + 2;
    endfunction

endpackage

// File: rtl/smm_prep.sv
module smm_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] mcand_mag,
    output logic [W-1:0] mplier_mag,
    output logic         prod_neg
);
    // Ones' complement magnitude: complement when the sign bit is set.
    always_comb begin
        mcand_mag  = mcand[W-1]  ? ~mcand  : mcand;
        mplier_mag = mplier[W-1] ? ~mplier : mplier;
        prod_neg   = mcand[W-1] ^ mplier[W-1];
    end
endmodule

// File: rtl/smm_step.sv
module smm_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] low,
    input  logic [W-1:0] cw,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] acc_nx,
    output logic [W-1:0] low_nx,
    output logic [W-1:0] cw_nx,
    output logic         add_taken
);
    logic [W-1:0] acc_sh;

    always_comb begin
        acc_sh    = acc >> 1;
        add_taken = low[0];
        if (low[0]) begin
            // Partial add: sum bits without carry, carries parked in cw.
            acc_nx = acc ^ mcand;
            cw_nx  = cw | (acc & mcand);
            low_nx = {low[W-1:1], 1'b0};
        end else begin
            // Pair shift; a parked carry now lines up with its target digit.
            low_nx = {acc[0], low[W-1:1]};
            acc_nx = acc_sh ^ cw;
            cw_nx  = cw & acc_sh;
        end
    end
endmodule

// File: rtl/smm_finish.sv
module smm_finish #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] cw,
    input  logic [W-1:0] low,
    input  logic         hold,
    input  logic         neg,
    output logic [W-1:0] acc_fin,
    output logic [W-1:0] low_fin
);
    logic [W:0]   sum_c;
    logic [W-1:0] resolved;
    logic [W:0]   sum_r;
    logic [W-1:0] rounded;

    always_comb begin
        // Full carry phase with end-around carry.
        sum_c    = {1'b0, acc} + {cw, 1'b0};
        resolved = sum_c[W-1:0] + {{(W-1){1'b0}}, sum_c[W]};
        // Round-off: add one when the top low bit is set (round mode only).
        sum_r    = {1'b0, resolved} + (W+1)'(1);
        if (!hold && low[W-1])
            rounded = sum_r[W-1:0] + {{(W-1){1'b0}}, sum_r[W]};
        else
            rounded = resolved;
        low_fin = hold ? low : '0;
        acc_fin = neg ? ~rounded : rounded;
    end
endmodule

// File: rtl/sm_frac_mul.sv
module sm_frac_mul
    import smm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         hold_mode,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] acc_in,
    output logic         done,
    output logic [W-1:0] acc_out,
    output logic [W-1:0] low_out
);
    localparam int SCW     = sc_width(W);
    localparam int SC_TOP  = sc_top(W);
    localparam int SC_INIT = sc_init(W);

    smm_state_e   state_q;
    logic [W-1:0] acc_q, low_q, cw_q, mc_q;
    logic [SCW-1:0] sc_q;
    logic         neg_q, done_q;
    smm_mode_e    mode_q;

    logic [W-1:0] mc_mag, mp_mag;
    logic         neg_c;
    logic [W-1:0] st_acc, st_low, st_cw;
    logic         st_add;
    logic [W-1:0] fin_acc, fin_low;

    smm_prep #(.W(W)) u_prep (
        .mcand     (mcand_in),
        .mplier    (acc_in),
        .mcand_mag (mc_mag),
        .mplier_mag(mp_mag),
        .prod_neg  (neg_c)
    );

    smm_step #(.W(W)) u_step (
        .acc      (acc_q),
        .low      (low_q),
        .cw       (cw_q),
        .mcand    (mc_q),
        .acc_nx   (st_acc),
        .low_nx   (st_low),
        .cw_nx    (st_cw),
        .add_taken(st_add)
    );

    smm_finish #(.W(W)) u_finish (
        .acc    (acc_q),
        .cw     (cw_q),
        .low    (low_q),
        .hold   (mode_q == MODE_HOLD),
        .neg    (neg_q),
        .acc_fin(fin_acc),
        .low_fin(fin_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            low_q   <= '0;
            cw_q    <= '0;
            mc_q    <= '0;
            sc_q    <= '0;
            neg_q   <= 1'b0;
            mode_q  <= MODE_ROUND;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mc_q    <= mc_mag;
                        low_q   <= mp_mag;
                        acc_q   <= '0;
                        cw_q    <= '0;
                        sc_q    <= SCW'(SC_INIT);
                        neg_q   <= neg_c;
                        mode_q  <= smm_mode_e'(hold_mode);
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    acc_q <= st_acc;
                    low_q <= st_low;
                    cw_q  <= st_cw;
                    if (!st_add) begin
                        sc_q <= sc_q + SCW'(1);
                        if (sc_q[SCW-1])
                            state_q <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    acc_q   <= fin_acc;
                    low_q   <= fin_low;
                    cw_q    <= '0;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done    = done_q;
    assign acc_out = acc_q;
    assign low_out = low_q;

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: operands are frozen while busy
    a_r7_operand_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(mc_q) && $stable(neg_q) && $stable(mode_q));

    // R3: counter stays inside its window while stepping
    a_r3_counter_window: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP) |-> (int'(sc_q) >= SC_INIT && int'(sc_q) <= SC_TOP));

    // R3: an add step is always followed by a shift step
    a_r3_add_then_shift: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP && low_q[0]) |=> (state_q == ST_STEP && !low_q[0]));

    // R2: the stored multiplicand is a magnitude
    a_r2_magnitude: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP) |-> !mc_q[W-1]);

    // R4: round mode clears the low register
    a_r4_round_clears_low: assert property (@(posedge clk) disable iff (rst)
        (done_q && mode_q == MODE_ROUND) |-> (low_q == '0));

endmodule

// File: tb/sm_frac_mul_test.sv
`timescale 1ns/1ps
module sm_frac_mul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        hold_mode = 1'b0;
    logic [15:0] mcand_in = '0;
    logic [15:0] acc_in = '0;
    logic        done;
    logic [15:0] acc_out, low_out;

    sm_frac_mul #(.W(16)) uut (
        .clk(clk), .rst(rst), .start(start), .hold_mode(hold_mode),
        .mcand_in(mcand_in), .acc_in(acc_in),
        .done(done), .acc_out(acc_out), .low_out(low_out)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [15:0] acc;
        logic [15:0] low;
        int          lat;
        int          t0;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic        prev_done = 1'b0;
    logic [15:0] last_acc = '0, last_low = '0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [15:0] mc, input logic [15:0] mp,
                                   input bit hold);
        exp_t        e;
        logic [15:0] a, m, hi, lo;
        logic [31:0] p;
        a  = mc[15] ? ~mc : mc;
        m  = mp[15] ? ~mp : mp;
        p  = (32'(a[14:0]) * 32'(m[14:0])) << 1;
        hi = p[31:16];
        lo = p[15:0];
        if (!hold) begin
            if (lo[15]) hi = hi + 16'd1;
            lo = '0;
        end
        if (mc[15] ^ mp[15]) hi = ~hi;
        e.acc = hi;
        e.low = lo;
        e.lat = 16 + $countones(m[14:0]);
        e.t0  = 0;
        e.req = "";
        return e;
    endfunction

    // Monitor: pop expected results as done pulses arrive.
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (done && prev_done)
                check(1'b0, "R8", "done longer than one cycle", 32'd1, 32'd0);
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
                end else begin
                    e = q.pop_front();
                    check(acc_out == e.acc, e.req, "acc_out", 32'(acc_out), 32'(e.acc));
                    check(low_out == e.low, e.req, "low_out", 32'(low_out), 32'(e.low));
                    check((cyc - e.t0) == e.lat, "R3", "latency",
                          32'(cyc - e.t0), 32'(e.lat));
                    last_acc = e.acc;
                    last_low = e.low;
                end
            end
        end
        prev_done = done;
    end

    task automatic issue(input logic [15:0] mc, input logic [15:0] mp,
                         input bit hold, input string req);
        exp_t e;
        @(negedge clk);
        mcand_in  = mc;
        acc_in    = mp;
        hold_mode = hold;
        start     = 1'b1;
        e         = model(mc, mp, hold);
        e.req     = req;
        @(negedge clk);
        start = 1'b0;
        e.t0  = cyc;
        q.push_back(e);
    endtask

    task automatic run_op(input logic [15:0] mc, input logic [15:0] mp,
                          input bit hold, input string req);
        issue(mc, mp, hold, req);
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        check(acc_out == 0 && low_out == 0 && done == 0, "R1", "in reset",
              {acc_out, low_out}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(acc_out == 0 && low_out == 0 && done == 0, "R1", "after reset",
              {acc_out, low_out}, 32'd0);

        run_op(16'h4000, 16'h4000, 1'b0, "R4");      // 0.5 * 0.5
        run_op(16'h0001, 16'h4000, 1'b0, "R4");      // rounds 0 up to 1
        run_op(16'h0001, 16'h4000, 1'b1, "R5");      // same, held low half
        run_op(16'h1234, 16'h5678, 1'b1, "R5");
        run_op(16'h7FFF, 16'h7FFF, 1'b0, "R9");      // full scale, 16'h7FFE
        check(last_acc == 16'h7FFE, "R9", "full scale", 32'(last_acc), 32'h7FFE);
        run_op(16'h7FFF, 16'h7FFF, 1'b1, "R9");
        run_op(16'hBFFF, 16'h4000, 1'b0, "R2");      // negative multiplicand
        run_op(16'h4000, 16'hBFFF, 1'b1, "R6");      // negative multiplier, hold
        run_op(16'hBFFF, 16'hBFFF, 1'b0, "R2");      // both negative
        run_op(16'hFFFF, 16'h2000, 1'b0, "R6");      // negative zero operand
        check(last_acc == 16'hFFFF, "R6", "negative zero result", 32'(last_acc), 32'hFFFF);
        run_op(16'h3000, 16'h0000, 1'b0, "R3");      // no add cycles
        run_op(16'h8000, 16'h8000, 1'b1, "R2");      // both most negative

        // R7: start pulsed mid-run with other operands
        issue(16'h2AAA, 16'h5555, 1'b1, "R7");
        repeat (5) @(negedge clk);
        mcand_in = 16'h7FFF; acc_in = 16'h7FFF; hold_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
        // R8: result held after done, no extra done appears
        repeat (20) @(negedge clk);
        check(acc_out == last_acc && low_out == last_low, "R8", "result held",
              {acc_out, low_out}, {last_acc, last_low});

        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr;
            run_op(a, b, lfsr[3], lfsr[3] ? "R5" : "R4");
        end

        check(q.size() == 0, "R8", "pending results", 32'(q.size()), 32'd0);
        finish_run();
    end
endmodule